// File: doc/BRIEF.md
# Flash Region Lock Protection Checker

This block stands in front of a flash programming engine. It judges each program or erase request before the request may start. The regular array of pages is split into sixteen equal regions, and each region has one lock fuse. A request that targets a page in a locked region is refused. A chip-wide erase is refused while any region is locked. The extra user page lies outside the regular array and is handled by its own write and erase commands. A chip erase never touches the user page, and the regular page commands may not be aimed at it.

Each request is presented for one cycle with `cmd_valid`. One cycle later the block answers in one of two ways. It either raises a one-cycle `go` pulse, with `go_user` telling the engine whether the target is the user page, or it sets a sticky error flag. The sticky flags are `lock_err` and `cmd_err`, and they hold until software strobes `status_rd`. The page-address width is a parameter, and the region index is always the top four bits of the page number.

Top module: `flc_lock_checker`

## Requirements
- R1: After reset, `go`, `go_user`, `lock_err` and `cmd_err` are all 0.
- R2: The region of a page is the top 4 bits of `page`. Region i is protected by `lock_fuses[i]` and by no other fuse bit.
- R3: Page write (code 1) and page erase (code 2), with `user_sel`=0 and the region unlocked, give `go`=1 and `go_user`=0 in the cycle after `cmd_valid`.
- R4: Code 1 or 2 with `user_sel`=0 aimed at a locked region gives no `go` and sets `lock_err` in the cycle after `cmd_valid`.
- R5: Chip erase (code 3) gives `go` only when every fuse bit is 0. Otherwise it sets `lock_err`. It never raises `go_user`, whatever the value of `user_sel`.
- R6: User-page write (code 4) and user-page erase (code 5) with `user_sel`=1 give `go`=1 and `go_user`=1, whatever the fuse bits are.
- R7: Code 1 or 2 with `user_sel`=1 sets `cmd_err` and gives no `go`. Code 4 or 5 with `user_sel`=0 also sets `cmd_err` and gives no `go`.
- R8: Codes 6 and 7 set `cmd_err` and give no `go`. Code 0 has no effect.
- R9: `lock_err` and `cmd_err` stay set until a `status_rd` strobe, which clears them in the next cycle.
- R10: When a `status_rd` strobe and a request that raises an error fall in the same cycle, that error flag is set in the next cycle and the other flag is cleared.
- R11: While `cmd_valid` is 0, all outputs and flags behave as if no request were made.
- R12: `go` is a single-cycle pulse for each accepted request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| cmd_valid | input | 1 | A request is presented this cycle |
| cmd_code | input | 3 | Request code (0 none, 1 page write, 2 page erase, 3 chip erase, 4 user write, 5 user erase) |
| page | input | PAGE_W | Target page number |
| lock_fuses | input | NUM_REGIONS | Lock fuse per region |
| user_sel | input | 1 | The request targets the user page |
| status_rd | input | 1 | Status read strobe; clears the error flags |
| go | output | 1 | One-cycle pulse: the request may proceed |
| go_user | output | 1 | With `go`: the accepted request acts on the user page |
| lock_err | output | 1 | Sticky: a request was refused by a lock |
| cmd_err | output | 1 | Sticky: an illegal code or target was given |

## Verification
A status read can fall in the same cycle as a request that raises an error, so clearing and setting one sticky flag contend in that cycle. The bench provokes this by first raising one flag. It then issues a refused request together with `status_rd`. The flag that the new request raises must read 1 in the next cycle, and the other flag must read 0. The reverse pairing is also tested: a strobe together with an accepted request must leave both flags clear while `go` pulses.

// File: rtl/flc_pkg.sv
package flc_pkg;

  localparam logic [2:0] CMD_NONE       = 3'd0;
  localparam logic [2:0] CMD_PG_WRITE   = 3'd1;
  localparam logic [2:0] CMD_PG_ERASE   = 3'd2;
  localparam logic [2:0] CMD_CHIP_ERASE = 3'd3;
  localparam logic [2:0] CMD_USR_WRITE  = 3'd4;
  localparam logic [2:0] CMD_USR_ERASE  = 3'd5;

  typedef struct packed {
    logic go;
    logic go_user;
    logic lock_err;
    logic cmd_err;
  } flc_verdict_t;

endpackage

// File: rtl/flc_region_lookup.sv
module flc_region_lookup #(
  parameter int PAGE_W      = 9,
  parameter int NUM_REGIONS = 16
) (
  input  logic [PAGE_W-1:0]      page,
  input  logic [NUM_REGIONS-1:0] lock_fuses,
  output logic                   region_locked,
  output logic                   any_locked
);
  localparam int REG_W = $clog2(NUM_REGIONS);

  logic [REG_W-1:0]       region_idx;
  logic [NUM_REGIONS-1:0] hit;

  assign region_idx = page[PAGE_W-1 -: REG_W];

  for (genvar i = 0; i < NUM_REGIONS; i++) begin : g_region
    assign hit[i] = lock_fuses[i] & (region_idx == REG_W'(i));
  end

  assign region_locked = |hit;
  assign any_locked    = |lock_fuses;
endmodule

// File: rtl/flc_cmd_judge.sv
module flc_cmd_judge
  import flc_pkg::*;
(
  input  logic         cmd_valid,
  input  logic [2:0]   cmd_code,
  input  logic         user_sel,
  input  logic         region_locked,
  input  logic         any_locked,
  output flc_verdict_t verdict
);
  always_comb begin
    verdict = '0;
    if (cmd_valid) begin
      case (cmd_code)
        CMD_NONE: ;
        CMD_PG_WRITE, CMD_PG_ERASE: begin
          if (user_sel)           verdict.cmd_err  = 1'b1;
          else if (region_locked) verdict.lock_err = 1'b1;
          else                    verdict.go       = 1'b1;
        end
        CMD_CHIP_ERASE: begin
          if (any_locked) verdict.lock_err = 1'b1;
          else            verdict.go       = 1'b1;
        end
        CMD_USR_WRITE, CMD_USR_ERASE: begin
          if (user_sel) begin
            verdict.go      = 1'b1;
            verdict.go_user = 1'b1;
          end else begin
            verdict.cmd_err = 1'b1;
          end
        end
        default: verdict.cmd_err = 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/flc_status_reg.sv
module flc_status_reg
  import flc_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  flc_verdict_t verdict,
  input  logic         status_rd,
  output logic         go,
  output logic         go_user,
  output logic         lock_err,
  output logic         cmd_err
);
  flc_verdict_t state_q, state_d;

  always_comb begin
    state_d.go       = verdict.go;
    state_d.go_user  = verdict.go_user;
    state_d.lock_err = verdict.lock_err | (state_q.lock_err & ~status_rd);
    state_d.cmd_err  = verdict.cmd_err  | (state_q.cmd_err  & ~status_rd);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= '0;
    else        state_q <= state_d;
  end

  assign go       = state_q.go;
  assign go_user  = state_q.go_user;
  assign lock_err = state_q.lock_err;
  assign cmd_err  = state_q.cmd_err;
endmodule

// File: rtl/flc_lock_checker.sv
module flc_lock_checker
  import flc_pkg::*;
#(
  parameter int PAGE_W      = 9,
  parameter int NUM_REGIONS = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cmd_valid,
  input  logic [2:0]             cmd_code,
  input  logic [PAGE_W-1:0]      page,
  input  logic [NUM_REGIONS-1:0] lock_fuses,
  input  logic                   user_sel,
  input  logic                   status_rd,
  output logic                   go,
  output logic                   go_user,
  output logic                   lock_err,
  output logic                   cmd_err
);
  logic [1:0]   rst_pipe;
  logic         rst_n_sync;
  logic         region_locked;
  logic         any_locked;
  flc_verdict_t verdict;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_n_sync = rst_pipe[1];

  flc_region_lookup #(.PAGE_W(PAGE_W), .NUM_REGIONS(NUM_REGIONS)) u_lookup (
    .page          (page),
    .lock_fuses    (lock_fuses),
    .region_locked (region_locked),
    .any_locked    (any_locked)
  );

  flc_cmd_judge u_judge (
    .cmd_valid     (cmd_valid),
    .cmd_code      (cmd_code),
    .user_sel      (user_sel),
    .region_locked (region_locked),
    .any_locked    (any_locked),
    .verdict       (verdict)
  );

  flc_status_reg u_status (
    .clk       (clk),
    .rst_n     (rst_n_sync),
    .verdict   (verdict),
    .status_rd (status_rd),
    .go        (go),
    .go_user   (go_user),
    .lock_err  (lock_err),
    .cmd_err   (cmd_err)
  );
endmodule

// File: rtl/flc_lock_checker_chk.sv
module flc_lock_checker_chk #(
  parameter int PAGE_W      = 9,
  parameter int NUM_REGIONS = 16
) (
  input logic                   clk,
  input logic                   rst_n_sync,
  input logic                   cmd_valid,
  input logic [2:0]             cmd_code,
  input logic [PAGE_W-1:0]      page,
  input logic [NUM_REGIONS-1:0] lock_fuses,
  input logic                   user_sel,
  input logic                   status_rd,
  input logic                   go,
  input logic                   go_user,
  input logic                   lock_err,
  input logic                   cmd_err
);
  localparam int REG_W = $clog2(NUM_REGIONS);

  logic pg_cmd;
  logic usr_cmd;
  assign pg_cmd  = (cmd_code == 3'd1) || (cmd_code == 3'd2);
  assign usr_cmd = (cmd_code == 3'd4) || (cmd_code == 3'd5);

  p_go_needs_req_r12: assert property (@(posedge clk) disable iff (!rst_n_sync)
    go |-> $past(cmd_valid));

  p_go_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (go && !cmd_valid) |=> !go);

  p_locked_page_r4: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (cmd_valid && pg_cmd && !user_sel && lock_fuses[page[PAGE_W-1 -: REG_W]])
      |=> (lock_err && !go));

  p_chip_locked_r5: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (cmd_valid && cmd_code == 3'd3 && (lock_fuses != '0)) |=> (lock_err && !go));

  p_chip_no_user_r5: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (cmd_valid && cmd_code == 3'd3) |=> !go_user);

  p_user_go_r6: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (cmd_valid && usr_cmd && user_sel) |=> (go && go_user));

  p_user_with_go_r6: assert property (@(posedge clk) disable iff (!rst_n_sync)
    go_user |-> go);

  p_wrong_target_r7: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (cmd_valid && ((pg_cmd && user_sel) || (usr_cmd && !user_sel))) |=> (cmd_err && !go));

  p_lock_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (lock_err && !status_rd) |=> lock_err);

  p_cmd_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (cmd_err && !status_rd) |=> cmd_err);

  p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (status_rd && !cmd_valid) |=> (!lock_err && !cmd_err));

  p_set_wins_r10: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (status_rd && cmd_valid && cmd_code == 3'd3 && (lock_fuses != '0)) |=> lock_err);
endmodule

bind flc_lock_checker flc_lock_checker_chk #(.PAGE_W(PAGE_W), .NUM_REGIONS(NUM_REGIONS)) u_chk (
  .clk        (clk),
  .rst_n_sync (rst_n_sync),
  .cmd_valid  (cmd_valid),
  .cmd_code   (cmd_code),
  .page       (page),
  .lock_fuses (lock_fuses),
  .user_sel   (user_sel),
  .status_rd  (status_rd),
  .go         (go),
  .go_user    (go_user),
  .lock_err   (lock_err),
  .cmd_err    (cmd_err)
);

// File: tb/tb_flc_lock_checker.sv
`timescale 1ns/1ps
module tb_flc_lock_checker;
  localparam int PW = 6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [2:0]  cmd_code = 3'd0;
  logic [PW-1:0] page = '0;
  logic [15:0] lock_fuses = '0;
  logic        user_sel = 1'b0;
  logic        status_rd = 1'b0;
  logic        go, go_user, lock_err, cmd_err;

  int total = 0;
  int fails = 0;

  always #2 clk = ~clk;

  flc_lock_checker #(.PAGE_W(PW), .NUM_REGIONS(16)) dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .page(page), .lock_fuses(lock_fuses), .user_sel(user_sel),
    .status_rd(status_rd), .go(go), .go_user(go_user),
    .lock_err(lock_err), .cmd_err(cmd_err)
  );

  // expected {go, go_user, lock_err, cmd_err} from the requirements
  function automatic logic [3:0] model(int code, int pg, logic [15:0] f, logic us);
    int region;
    region = pg >> (PW - 4);
    case (code)
      0:       return 4'b0000;
      1, 2:    if (us) return 4'b0001; else if (f[region]) return 4'b0010; else return 4'b1000;
      3:       return (f != 16'h0) ? 4'b0010 : 4'b1000;
      4, 5:    return us ? 4'b1100 : 4'b0001;
      default: return 4'b0001;
    endcase
  endfunction

  task automatic check(string req, logic [3:0] exp);
    logic [3:0] act;
    act = {go, go_user, lock_err, cmd_err};
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: outputs {go,go_user,lock_err,cmd_err} actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic send(int code, int pg, logic [15:0] f, logic us, logic rd);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_code = 3'(code); page = PW'(pg);
    lock_fuses = f; user_sel = us; status_rd = rd;
    @(negedge clk);
    cmd_valid = 1'b0; status_rd = 1'b0;
  endtask

  task automatic clear_flags();
    @(negedge clk);
    status_rd = 1'b1;
    @(negedge clk);
    status_rd = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++; total++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    logic [15:0] pat;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 reset", 4'b0000);

    // R2 R3 R4: every page against single-fuse, empty and full patterns
    for (int code = 1; code <= 2; code++) begin
      for (int k = 0; k < 18; k++) begin
        pat = (k < 16) ? (16'h1 << k) : ((k == 16) ? 16'h0000 : 16'hFFFF);
        for (int pg = 0; pg < (1 << PW); pg++) begin
          send(code, pg, pat, 1'b0, 1'b0);
          check("R2/R3/R4 page request", model(code, pg, pat, 1'b0));
          clear_flags();
          check("R12/R9 pulse ends and flags clear", 4'b0000);
        end
      end
    end

    // R5 R6 R7 R8: every code, both targets, several fuse patterns
    for (int code = 0; code < 8; code++) begin
      for (int u = 0; u < 2; u++) begin
        for (int k = 0; k < 4; k++) begin
          pat = (k == 0) ? 16'h0000 : (k == 1) ? 16'h8000 : (k == 2) ? 16'h0001 : 16'hA5A5;
          send(code, 37, pat, u[0], 1'b0);
          check("R5/R6/R7/R8 code sweep", model(code, 37, pat, u[0]));
          clear_flags();
        end
      end
    end

    // R11: codes held with cmd_valid low do nothing
    @(negedge clk);
    cmd_code = 3'd6; user_sel = 1'b1; lock_fuses = 16'hFFFF;
    @(negedge clk);
    @(negedge clk);
    check("R11 idle request ignored", 4'b0000);

    // R9: lock_err sticky over idle cycles, then cleared
    send(3, 0, 16'h0010, 1'b0, 1'b0);
    repeat (3) @(negedge clk);
    check("R9 lock_err held", 4'b0010);
    clear_flags();
    check("R9 lock_err cleared", 4'b0000);

    // R10: cmd_err pending, locked chip erase with status read in same cycle
    send(7, 0, 16'h0, 1'b0, 1'b0);
    check("R8 cmd_err raised", 4'b0001);
    send(3, 0, 16'h0100, 1'b0, 1'b1);
    check("R10 set wins, other cleared", 4'b0010);
    // R10 reverse: lock_err pending, bad target with status read
    send(1, 5, 16'h0, 1'b1, 1'b1);
    check("R10 cmd_err set, lock_err cleared", 4'b0001);
    // status read with an accepted request: both flags clear while go pulses
    send(4, 0, 16'hFFFF, 1'b1, 1'b1);
    check("R10 read with accepted request", 4'b1100);
    @(negedge clk);
    check("R12 go single cycle", 4'b0000);

    // R5: chip erase with user_sel set never raises go_user
    send(3, 63, 16'h0, 1'b1, 1'b0);
    check("R5 chip erase spares user page", 4'b1000);

    // R1 again: reset mid-state
    send(3, 0, 16'h0001, 1'b0, 1'b0);
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 reset clears flags", 4'b0000);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule